// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block loads the control words of an integer-N frequency synthesizer over a three-wire serial link: a serial clock, a serial data line and a set of strobe lines. On each rising edge of the serial clock one data bit, least significant first, enters one of three shift targets. These are a working word register, a shadow word register that mirrors the contents of nonvolatile storage, and a short enhancement register. The target is chosen by the level of the strobes. A rising edge on the word-write strobe copies the working word into a holding register. A rising edge on the parallel-load line copies the holding word into the shadow register.

A frequency-select input chooses whether the holding word or the shadow word drives the divider word output. The enhancement word reaches its output only while the active-low enhancement mode input is low. When enhancement mode is active and the readback bit of the enhancement word is set, the data-out pin shows the lowest bit of the shadow register. Each serial clock edge aimed at the shadow register then shifts one bit out, so the stored word can be read back serially.

All serial inputs are asynchronous to the system clock. They pass through a synchronizer chain and are edge-detected in the system clock domain, so each serial clock edge or strobe edge causes exactly one action.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, the divider word is zero for both frequency-select values, the enhancement word is zero and the data-out pin is low.
- R2: Bits are taken on the rising edge of the serial clock, and the first bit shifted ends up at bit 0. After WORD_W shifts, the working register equals the word sent.
- R3: Target decode uses the levels (write-enable, word-write strobe). (0,0) shifts the working register. (0,1) shifts the shadow register. (1,0) shifts the enhancement register when enhancement mode is low.
- R4: The combination (1,1) shifts no register. The combination (1,0) with enhancement mode high also shifts no register.
- R5: A rising edge of the word-write strobe copies the working register into the holding register.
- R6: A rising edge of the parallel-load line copies the holding register into the shadow register. If a shadow shift falls in the same cycle, the load wins and that bit is dropped.
- R7: With frequency-select low, the divider word shows the holding register. With frequency-select high, it shows the shadow register.
- R8: The enhancement word output equals the enhancement register while enhancement mode is low, and is zero while it is high.
- R9: The data-out pin equals bit 0 of the shadow register when enhancement mode is low and enhancement bit RDBK_BIT (default 0) is 1. Otherwise it is low. Each shadow shift presents the next bit.
- R10: A strobe held high causes no further transfer. The holding register changes only on a word-write rising edge, and a held parallel-load line does not overwrite later shadow shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| sec_wr_i | input | 1 | Word-write strobe; also a target-select line |
| enh_we_i | input | 1 | Enhancement write enable; also a target-select line |
| enh_mode_ni | input | 1 | Enhancement mode, active low |
| fsel_i | input | 1 | Frequency-select: picks holding or shadow word |
| pload_i | input | 1 | Parallel-load strobe, holding to shadow |
| div_word_o | output | WORD_W | Active divider word |
| enh_word_o | output | ENH_W | Gated enhancement word |
| dout_o | output | 1 | Serial readback of the shadow register |

## Verification
A wrong working register stays hidden until the next word-write edge. It then shows on the divider word with frequency-select low, a few system cycles after that edge. A wrong shadow register shows at once on the divider word with frequency-select high, and bit by bit on the data-out pin during readback. A wrong decode or lost edge corrupts a word that is later read back in full. The bench therefore checks every word through both select values and through a bit-wise readback, with a mirror model that tracks each register from the strobe sequence.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_PRI  = 2'd1,
      TGT_SHD  = 2'd2,
      TGT_ENH  = 2'd3
   } tgt_e;

   // positions of the inputs inside the synchronizer bank
   localparam int IX_SCLK = 0;
   localparam int IX_SDAT = 1;
   localparam int IX_SWR  = 2;
   localparam int IX_EWE  = 3;
   localparam int IX_ENHN = 4;
   localparam int IX_FSEL = 5;
   localparam int IX_PLD  = 6;
   localparam int N_ASYNC = 7;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
   parameter int N      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] sync_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("synth_cfg_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("synth_cfg_sync: N must be at least 1");
   end

   logic [STAGES-1:0][N-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[LAST];
endmodule

// File: rtl/synth_cfg_shreg.sv
module synth_cfg_shreg #(
   parameter int W         = 20,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         shift_i,
   input  logic         din_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] q_o
);
   if (W < 2) begin : g_bad_w
      $error("synth_cfg_shreg: W must be at least 2");
   end

   logic [W-1:0] next_shift;

   if (LSB_FIRST) begin : g_lsb_first
      // new bit enters at the top and walks down to bit 0
      assign next_shift = {din_i, q_o[W-1:1]};
   end else begin : g_msb_first
      assign next_shift = {q_o[W-2:0], din_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_o <= '0;
      end else if (load_i) begin
         q_o <= load_val_i;
      end else if (shift_i) begin
         q_o <= next_shift;
      end
   end
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
   import synth_cfg_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sclk_s_i,
   input  logic swr_s_i,
   input  logic ewe_s_i,
   input  logic enhn_s_i,
   input  logic pld_s_i,
   output tgt_e tgt_o,
   output logic pri_sh_o,
   output logic shd_sh_o,
   output logic enh_sh_o,
   output logic sec_cp_o,
   output logic shd_ld_o
);
   logic sclk_q, swr_q, pld_q;
   logic sclk_rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q <= 1'b0;
         swr_q  <= 1'b0;
         pld_q  <= 1'b0;
      end else begin
         sclk_q <= sclk_s_i;
         swr_q  <= swr_s_i;
         pld_q  <= pld_s_i;
      end
   end

   assign sclk_rise = sclk_s_i & ~sclk_q;
   assign sec_cp_o  = swr_s_i & ~swr_q;
   assign shd_ld_o  = pld_s_i & ~pld_q;

   always_comb begin
      unique case ({ewe_s_i, swr_s_i})
         2'b00:   tgt_o = TGT_PRI;
         2'b01:   tgt_o = TGT_SHD;
         2'b10:   tgt_o = enhn_s_i ? TGT_NONE : TGT_ENH;
         default: tgt_o = TGT_NONE;
      endcase
   end

   assign pri_sh_o = sclk_rise && (tgt_o == TGT_PRI);
   // a parallel load in the same cycle takes precedence over a shadow shift
   assign shd_sh_o = sclk_rise && (tgt_o == TGT_SHD) && !shd_ld_o;
   assign enh_sh_o = sclk_rise && (tgt_o == TGT_ENH);
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
   import synth_cfg_pkg::*;
#(
   parameter int WORD_W         = 20,
   parameter int ENH_W          = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int RDBK_BIT       = 0,
   parameter bit FSEL_HI_SHADOW = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              sec_wr_i,
   input  logic              enh_we_i,
   input  logic              enh_mode_ni,
   input  logic              fsel_i,
   input  logic              pload_i,
   output logic [WORD_W-1:0] div_word_o,
   output logic [ENH_W-1:0]  enh_word_o,
   output logic              dout_o
);
   if (WORD_W < 2) begin : g_bad_word
      $error("synth_cfg_port: WORD_W must be at least 2");
   end
   if (ENH_W < 2) begin : g_bad_enh
      $error("synth_cfg_port: ENH_W must be at least 2");
   end
   if (RDBK_BIT < 0 || RDBK_BIT >= ENH_W) begin : g_bad_rdbk
      $error("synth_cfg_port: RDBK_BIT outside the enhancement word");
   end

   logic [N_ASYNC-1:0] raw, syn;
   logic sdat_s, enhn_s, fsel_s;
   tgt_e tgt;
   logic pri_sh, shd_sh, enh_sh, sec_cp, shd_ld;
   logic [WORD_W-1:0] pri_q, sec_q, shd_q;
   logic [ENH_W-1:0]  enh_q;
   logic rdbk_en;

   always_comb begin
      raw          = '0;
      raw[IX_SCLK] = ser_clk_i;
      raw[IX_SDAT] = ser_dat_i;
      raw[IX_SWR]  = sec_wr_i;
      raw[IX_EWE]  = enh_we_i;
      raw[IX_ENHN] = enh_mode_ni;
      raw[IX_FSEL] = fsel_i;
      raw[IX_PLD]  = pload_i;
   end

   synth_cfg_sync #(.N(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (raw),
      .sync_o  (syn)
   );

   assign sdat_s = syn[IX_SDAT];
   assign enhn_s = syn[IX_ENHN];
   assign fsel_s = syn[IX_FSEL];

   synth_cfg_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sclk_s_i (syn[IX_SCLK]),
      .swr_s_i  (syn[IX_SWR]),
      .ewe_s_i  (syn[IX_EWE]),
      .enhn_s_i (enhn_s),
      .pld_s_i  (syn[IX_PLD]),
      .tgt_o    (tgt),
      .pri_sh_o (pri_sh),
      .shd_sh_o (shd_sh),
      .enh_sh_o (enh_sh),
      .sec_cp_o (sec_cp),
      .shd_ld_o (shd_ld)
   );

   synth_cfg_shreg #(.W(WORD_W), .LSB_FIRST(1'b1)) u_pri (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (pri_sh),
      .din_i      (sdat_s),
      .load_i     (1'b0),
      .load_val_i ('0),
      .q_o        (pri_q)
   );

   synth_cfg_shreg #(.W(WORD_W), .LSB_FIRST(1'b1)) u_shd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (shd_sh),
      .din_i      (sdat_s),
      .load_i     (shd_ld),
      .load_val_i (sec_q),
      .q_o        (shd_q)
   );

   synth_cfg_shreg #(.W(ENH_W), .LSB_FIRST(1'b1)) u_enh (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (enh_sh),
      .din_i      (sdat_s),
      .load_i     (1'b0),
      .load_val_i ('0),
      .q_o        (enh_q)
   );

   // holding register: written only on a word-write rising edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sec_q <= '0;
      end else if (sec_cp) begin
         sec_q <= pri_q;
      end
   end

   if (FSEL_HI_SHADOW) begin : g_mux_hi_shadow
      assign div_word_o = fsel_s ? shd_q : sec_q;
   end else begin : g_mux_hi_holding
      assign div_word_o = fsel_s ? sec_q : shd_q;
   end

   assign enh_word_o = enhn_s ? '0 : enh_q;
   assign rdbk_en    = !enhn_s && enh_q[RDBK_BIT];
   assign dout_o     = rdbk_en & shd_q[0];
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
   import synth_cfg_pkg::*;
#(
   parameter int WORD_W = 20,
   parameter int ENH_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input tgt_e              tgt,
   input logic              pri_sh,
   input logic              shd_sh,
   input logic              enh_sh,
   input logic              sec_cp,
   input logic              shd_ld,
   input logic              sdat_s,
   input logic              enhn_s,
   input logic [WORD_W-1:0] pri_q,
   input logic [WORD_W-1:0] sec_q,
   input logic [WORD_W-1:0] shd_q,
   input logic [ENH_W-1:0]  enh_q,
   input logic [ENH_W-1:0]  enh_word_o
);
   AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({pri_sh, shd_sh, enh_sh})); // R3

   AST_PRI_LSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pri_sh |=> (pri_q[WORD_W-1] == $past(sdat_s))
                 && (pri_q[WORD_W-2:0] == $past(pri_q[WORD_W-1:1]))); // R2

   AST_NO_TARGET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt == TGT_NONE && !shd_ld) |=> ($stable(pri_q) && $stable(shd_q) && $stable(enh_q))); // R4

   AST_SEC_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_cp |=> (sec_q == $past(pri_q))); // R5

   AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sec_cp |=> $stable(sec_q)); // R10

   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shd_ld |=> (shd_q == $past(sec_q))); // R6

   AST_ENH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enhn_s |-> (enh_word_o == '0)); // R8
endmodule

bind synth_cfg_port synth_cfg_chk #(.WORD_W(WORD_W), .ENH_W(ENH_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tgt        (tgt),
   .pri_sh     (pri_sh),
   .shd_sh     (shd_sh),
   .enh_sh     (enh_sh),
   .sec_cp     (sec_cp),
   .shd_ld     (shd_ld),
   .sdat_s     (sdat_s),
   .enhn_s     (enhn_s),
   .pri_q      (pri_q),
   .sec_q      (sec_q),
   .shd_q      (shd_q),
   .enh_q      (enh_q),
   .enh_word_o (enh_word_o)
);

// File: tb/synth_cfg_port_bench.sv
`timescale 1ns/1ps
module synth_cfg_port_bench;
   localparam int WW = 20;
   localparam int EW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 0, sdat = 0, swr = 0, ewe = 0, enhn = 0, fsel = 0, pld = 0;
   logic [WW-1:0] div_word;
   logic [EW-1:0] enh_word;
   logic dout;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [WW-1:0] m_pri = '0, m_sec = '0, m_shd = '0;
   logic [EW-1:0] m_enh = '0;

   always #10 clk = ~clk;

   synth_cfg_port u_synth_cfg_port (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ser_clk_i   (sclk),
      .ser_dat_i   (sdat),
      .sec_wr_i    (swr),
      .enh_we_i    (ewe),
      .enh_mode_ni (enhn),
      .fsel_i      (fsel),
      .pload_i     (pld),
      .div_word_o  (div_word),
      .enh_word_o  (enh_word),
      .dout_o      (dout)
   );

   function automatic logic [WW-1:0] f_sh_word(input logic [WW-1:0] r, input logic b);
      return {b, r[WW-1:1]};
   endfunction

   function automatic logic [EW-1:0] f_sh_enh(input logic [EW-1:0] r, input logic b);
      return {b, r[EW-1:1]};
   endfunction

   function automatic logic f_dout();
      return (!enhn && m_enh[0]) ? m_shd[0] : 1'b0;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic ser_bit(input logic b);
      sdat = b;
      tick(3);
      sclk = 1'b1;
      case ({ewe, swr})
         2'b00: m_pri = f_sh_word(m_pri, b);
         2'b01: m_shd = f_sh_word(m_shd, b);
         2'b10: if (!enhn) m_enh = f_sh_enh(m_enh, b);
         default: ;
      endcase
      tick(3);
      sclk = 1'b0;
      tick(1);
   endtask

   task automatic shift_n(input logic [31:0] w, input int n);
      for (int i = 0; i < n; i++) ser_bit(w[i]);
   endtask

   task automatic set_swr(input logic v);
      if (v && !swr) m_sec = m_pri;
      swr = v;
      tick(4);
   endtask

   task automatic set_pld(input logic v);
      if (v && !pld) m_shd = m_sec;
      pld = v;
      tick(4);
   endtask

   task automatic set_lines(input logic e_we, input logic e_n);
      ewe  = e_we;
      enhn = e_n;
      tick(4);
   endtask

   task automatic chk_words(input string tag);
      fsel = 1'b0;
      tick(4);
      chk({tag, " holding via fsel=0"}, 32'(div_word), 32'(m_sec));
      fsel = 1'b1;
      tick(4);
      chk({tag, " shadow via fsel=1"}, 32'(div_word), 32'(m_shd));
      fsel = 1'b0;
      tick(4);
   endtask

   task automatic chk_outs(input string tag);
      chk({tag, " enh word"}, 32'(enh_word), enhn ? 32'd0 : 32'(m_enh));
      chk({tag, " dout"}, 32'(dout), 32'(f_dout()));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1: watchdog expired, actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      logic [31:0] w;
      seed = int'($urandom(32'h5EED_0042));
      tick(5);
      rst_n = 1'b1;
      tick(4);

      // R1: reset state
      chk_words("R1 reset");
      chk("R1 reset enh word", 32'(enh_word), 32'd0);
      chk("R1 reset dout", 32'(dout), 32'd0);

      // R2 / R3 / R5: shift working word, copy to holding
      shift_n(32'h0_0001, WW);
      set_swr(1'b1);
      set_swr(1'b0);
      chk_words("R2 lsb-first single bit");
      shift_n(32'h0_A5C3E, WW);
      set_swr(1'b1);
      set_swr(1'b0);
      chk_words("R5 holding copy after R3 primary shift");

      // R3: shadow target
      set_swr(1'b1);
      shift_n(32'h0_3C0F5, WW);
      set_swr(1'b0);
      chk_words("R3 shadow target");

      // R3 / R8: enhancement target and gating
      set_lines(1'b1, 1'b0);
      shift_n(32'h6D, EW);
      set_lines(1'b0, 1'b0);
      chk("R3 enh target loaded", 32'(enh_word), 32'(m_enh));
      set_lines(1'b0, 1'b1);
      chk("R8 enh gated off", 32'(enh_word), 32'd0);
      set_lines(1'b0, 1'b0);
      chk("R8 enh gated on", 32'(enh_word), 32'h6D);

      // R4: illegal combinations shift nothing
      shift_n(32'h0_12345, WW);       // change working word first
      set_lines(1'b1, 1'b1);
      shift_n(32'hF, 4);
      set_swr(1'b1);                  // (1,1)
      shift_n(32'hA, 4);
      set_swr(1'b0);
      set_lines(1'b0, 1'b0);
      chk("R4 enh untouched", 32'(enh_word), 32'(m_enh));
      set_swr(1'b1);
      set_swr(1'b0);
      chk_words("R4 working and shadow untouched");

      // R6 / R10: parallel load, held strobe does not reload
      set_pld(1'b1);
      chk_words("R6 parallel load");
      set_swr(1'b1);
      shift_n(32'h5, 3);
      chk_words("R10 held load keeps shifted shadow");
      set_pld(1'b0);

      // R6: load and shadow shift in the same cycle, load wins
      sdat = 1'b1;
      tick(3);
      pld  = 1'b1;
      sclk = 1'b1;
      m_shd = m_sec;
      tick(4);
      sclk = 1'b0;
      tick(2);
      pld = 1'b0;
      tick(3);
      chk_words("R6 load beats shift");
      set_swr(1'b0);

      // R10: held word-write strobe copies once
      shift_n(32'h0_0BEEF, WW);
      set_swr(1'b1);
      set_lines(1'b1, 1'b0);          // (1,1): nothing shifts
      set_lines(1'b0, 1'b0);
      chk_words("R10 single copy while held");
      set_swr(1'b0);

      // R9: serial readback of the shadow register
      set_lines(1'b1, 1'b0);
      shift_n(32'h01, EW);
      set_lines(1'b0, 1'b0);
      set_swr(1'b1);
      chk("R9 readback first bit", 32'(dout), 32'(f_dout()));
      for (int i = 0; i < WW; i++) begin
         ser_bit(1'b0);
         chk("R9 readback bit", 32'(dout), 32'(f_dout()));
      end
      shift_n(32'h0_00001, WW);
      set_lines(1'b0, 1'b1);
      chk("R9 dout off when mode high", 32'(dout), 32'd0);
      set_lines(1'b0, 1'b0);
      chk("R9 dout on when mode low", 32'(dout), 32'd1);
      set_swr(1'b0);

      // random mixture
      for (int it = 0; it < 14; it++) begin
         int tsel;
         w = $urandom;
         tsel = int'($urandom % 3);
         if (tsel == 0) begin
            set_lines(1'b0, 1'b0);
            set_swr(1'b0);
            shift_n(w, WW);
         end else if (tsel == 1) begin
            set_lines(1'b0, 1'b0);
            set_swr(1'b1);
            shift_n(w, WW);
            set_swr(1'b0);
         end else begin
            set_swr(1'b0);
            set_lines(1'b1, 1'b0);
            shift_n(w, EW);
            set_lines(1'b0, 1'b0);
         end
         if ($urandom % 2 == 1) begin
            set_swr(1'b1);
            set_swr(1'b0);
         end
         if ($urandom % 2 == 1) begin
            set_pld(1'b1);
            set_pld(1'b0);
         end
         set_lines(1'b0, logic'($urandom % 2));
         chk_words("R7 random");
         chk_outs("R8 R9 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule